// File: doc/BRIEF.md
# Module Clock-Stop Gate Bank

This block owns one clock gate per peripheral module, all derived from a single source clock. A register holds one stop bit per gate: a 1 holds that module's clock low, and a 0 lets it run. Beside it sits a read-only status register with the same bit layout. A status bit reads 1 until the clock it reports on has actually been observed running. Software therefore clears a stop bit and then polls the matching status bit until it drops to 0. A start is never instantaneous, and the confirmation comes from the gated clock itself rather than from the request.

Each gate's confirmation is formed inside the gated domain. A pair of flops clocked by the gated clock load a constant 1, and the stop bit clears them asynchronously. Their output crosses back into the source domain through a two-flop synchroniser. The bus side is a plain read/write port whose data width (8, 16 or 32 bits) is a per-instance parameter. Gates are packed into as many words as that width needs. The top address bit selects the status register and the low bits select the word.

Top module: `clkstop_bank`

## Requirements
- R1: After reset, every stop bit and every status bit reads 1, and every module clock is held low.
- R2: Gate g sits at bit g mod BUS_W of word g div BUS_W. Address MSB 0 selects the stop register and 1 selects the status register. Bit positions at or above NUM_GATES, and word indices at or above the word count, read 0.
- R3: A write to a stop word replaces the implemented bits of that word with the write data and leaves every other word unchanged.
- R4: When a write sets a running gate's stop bit, the two reads issued on the next two cycles still return 0 for that status bit. Every later read returns 1.
- R5: When a write clears a stop bit, the four reads issued on the next four cycles return 1 for that status bit. Reads from the fifth cycle on return 0.
- R6: Writes to the status address leave both the stop register and the status register unchanged.
- R7: A module clock stays low while its stop bit is 1. While the bit is 0, the module clock follows the source clock's high phase.
- R8: A read request returns the addressed word on bus_rdata from the next cycle until the next read. A read changes no state.
- R9: Changing one gate's stop bit leaves every other gate's clock and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for the bus and for every gate |
| rst | input | 1 | Active-high asynchronous reset |
| bus_rd | input | 1 | Read request, sampled on the rising edge |
| bus_wr | input | 1 | Write request, sampled on the rising edge |
| bus_addr | input | ADDR_W | MSB selects stop (0) or status (1); low bits select the word |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| mod_clk | output | NUM_GATES | Gated module clocks |

## Verification
On every cycle, the assertions check four things. A stop-word write lands exactly. A write to the status address leaves the stop bits untouched. A status bit is back at 1 two cycles after its stop bit settles at 1. A status bit never shows 0 unless the stop bit was 0 two cycles earlier. Only the bench scenarios can show the rest. These are the exact poll counts seen through the bus on start and on stop, the level of each gated clock in the high phase, the zero padding of unused bits, and the independence of neighbouring gates under random read-modify-write traffic.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // flops on each side of the acknowledge round trip
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        SEL_STOP = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    function automatic int words_for(input int gates, input int width);
        return (gates + width - 1) / width;
    endfunction

    function automatic int idx_bits(input int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction

endpackage

// File: rtl/clkstop_icg.sv
`timescale 1ns/1ps
module clkstop_icg (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_l;

    // enable only changes while the source clock is low
    always_latch begin
        if (!clk) en_l = en;
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/clkstop_ack.sv
`timescale 1ns/1ps
module clkstop_ack
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gclk,
    input  logic stop,
    output logic live
);
    logic                   clr;
    logic [SYNC_STAGES-1:0] run_d, run_q;
    logic [SYNC_STAGES-1:0] sync_d, sync_q;

    assign clr = rst | stop;

    // gated side: fills with ones only when the gated clock really ticks
    always_comb begin
        run_d = {run_q[SYNC_STAGES-2:0], 1'b1};
    end

    always_ff @(posedge gclk or posedge clr) begin
        if (clr) run_q <= '0;
        else     run_q <= run_d;
    end

    // source side: bring the running flag back
    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], run_q[SYNC_STAGES-1]};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign live = sync_q[SYNC_STAGES-1];

    // R4: stopped for two sampled cycles means no longer confirmed
    a_r4_status_after_stop: assert property (@(posedge clk) disable iff (rst)
        (stop && $past(stop) && $past(stop, 2)) |-> !live);

    // R5: confirmation only if the gate was released two cycles back
    a_r5_live_needs_release: assert property (@(posedge clk) disable iff (rst)
        live |-> !$past(stop, 2));
endmodule

// File: rtl/clkstop_regs.sv
`timescale 1ns/1ps
module clkstop_regs
    import clkstop_pkg::*;
#(
    parameter int NUM_GATES = 12,
    parameter int BUS_W     = 8,
    localparam int NW       = words_for(NUM_GATES, BUS_W),
    localparam int IDX_W    = idx_bits(NW),
    localparam int ADDR_W   = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [BUS_W-1:0]     wdata_i,
    input  logic [NUM_GATES-1:0] status_i,
    output logic [NUM_GATES-1:0] stop_o,
    output logic [BUS_W-1:0]     rdata_o
);
    localparam int PAD_W = NW * BUS_W;
    localparam int W0    = (NUM_GATES < BUS_W) ? NUM_GATES : BUS_W;

    typedef struct packed {
        logic [NUM_GATES-1:0] stop;
        logic [BUS_W-1:0]     rdata;
    } regs_t;

    regs_t              regs_d, regs_q;
    reg_sel_e           sel;
    logic [IDX_W-1:0]   word;
    logic [PAD_W-1:0]   stop_pad, stat_pad;
    logic               word_ok;
    int                 wbase;

    assign sel     = reg_sel_e'(addr_i[ADDR_W-1]);
    assign word    = addr_i[IDX_W-1:0];
    assign word_ok = (int'(word) < NW);

    always_comb begin
        stop_pad = '0;
        stat_pad = '0;
        stop_pad[NUM_GATES-1:0] = regs_q.stop;
        stat_pad[NUM_GATES-1:0] = status_i;
        wbase  = int'(word) * BUS_W;
        regs_d = regs_q;

        if (wr_i && sel == SEL_STOP && word_ok) begin
            for (int b = 0; b < BUS_W; b++) begin
                if (wbase + b < NUM_GATES) regs_d.stop[wbase + b] = wdata_i[b];
            end
        end

        if (rd_i) begin
            if (!word_ok)              regs_d.rdata = '0;
            else if (sel == SEL_STAT)  regs_d.rdata = stat_pad[wbase +: BUS_W];
            else                       regs_d.rdata = stop_pad[wbase +: BUS_W];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            regs_q.stop  <= '1;
            regs_q.rdata <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign stop_o  = regs_q.stop;
    assign rdata_o = regs_q.rdata;

    // R3: a write to word 0 lands on the low stop bits
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_STOP && word == '0)
        |=> (regs_q.stop[W0-1:0] == $past(wdata_i[W0-1:0])));

    // R6: the status address is not writable
    a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_STAT) |=> $stable(regs_q.stop));
endmodule

// File: rtl/clkstop_bank.sv
`timescale 1ns/1ps
module clkstop_bank
    import clkstop_pkg::*;
#(
    parameter int NUM_GATES = 12,
    parameter int BUS_W     = 8,
    localparam int NW       = words_for(NUM_GATES, BUS_W),
    localparam int IDX_W    = idx_bits(NW),
    localparam int ADDR_W   = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic [NUM_GATES-1:0] mod_clk
);
    logic [NUM_GATES-1:0] stop;
    logic [NUM_GATES-1:0] live;
    logic [NUM_GATES-1:0] status;

    assign status = ~live;

    clkstop_regs #(
        .NUM_GATES (NUM_GATES),
        .BUS_W     (BUS_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .rd_i     (bus_rd),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .status_i (status),
        .stop_o   (stop),
        .rdata_o  (bus_rdata)
    );

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        clkstop_icg icg_i (
            .clk  (clk),
            .en   (~stop[g]),
            .gclk (mod_clk[g])
        );

        clkstop_ack ack_i (
            .clk  (clk),
            .rst  (rst),
            .gclk (mod_clk[g]),
            .stop (stop[g]),
            .live (live[g])
        );
    end
endmodule

// File: tb/clkstop_bank_tb.sv
`timescale 1ns/1ps
module clkstop_bank_tb_top;
    localparam int NG  = 12;
    localparam int BW  = 8;
    localparam int NW  = 2;
    localparam int AW  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic [NG-1:0] mod_clk;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    logic stop_m [NG];

    always #4 clk = ~clk;

    clkstop_bank #(.NUM_GATES(NG), .BUS_W(BW)) dut_i (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mod_clk(mod_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // settled model: status equals stop, unused bits zero
    function automatic logic [BW-1:0] exp_word(input int w);
        logic [BW-1:0] v = '0;
        for (int b = 0; b < BW; b++)
            if (w * BW + b < NG) v[b] = stop_m[w * BW + b];
        return v;
    endfunction

    function automatic logic [NG-1:0] exp_clk();
        logic [NG-1:0] v;
        for (int g = 0; g < NG; g++) v[g] = ~stop_m[g];
        return v;
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [BW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a[AW-1] == 1'b0 && a[0] < NW)
            for (int b = 0; b < BW; b++)
                if (a[0] * BW + b < NG) stop_m[a[0] * BW + b] = d[b];
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [BW-1:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic snap_clk(output logic [NG-1:0] c);
        @(posedge clk);
        #1 c = mod_clk;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [BW-1:0] d;
        logic [NG-1:0] c;
        for (int w = 0; w < NW; w++) begin
            do_read(2'(w), d);
            check(d == exp_word(w), req, d, exp_word(w));
            do_read(2'(2 + w), d);
            check(d == exp_word(w), req, d, exp_word(w));
        end
        snap_clk(c);
        check(c == exp_clk(), req, c, exp_clk());
    endtask

    initial begin
        logic [BW-1:0] d;
        logic [NG-1:0] c;
        int cnt;
        void'($urandom(32'd1234));
        for (int g = 0; g < NG; g++) stop_m[g] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R2: reset values and packing (word1 has four gates)
        check_all("R1");
        do_read(2'b01, d);
        check(d == 8'h0F, "R2", d, 8'h0F);

        // R5: start gate 3 with read-modify-write, count polls
        do_read(2'b00, d);
        do_write(2'b00, d & ~8'h08);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            do_read(2'b10, d);
            if (d[3]) cnt++; else break;
        end
        check(cnt == 4, "R5", cnt, 4);
        snap_clk(c);
        check(c == 12'h008, "R7", c, 12'h008);
        // R9: neighbours still stopped and unconfirmed
        do_read(2'b10, d);
        check(d == 8'hF7, "R9", d, 8'hF7);

        // R4: stop gate 3 again
        do_read(2'b00, d);
        do_write(2'b00, d | 8'h08);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            do_read(2'b10, d);
            if (!d[3]) cnt++; else break;
        end
        check(cnt == 2, "R4", cnt, 2);
        snap_clk(c);
        check(c == 12'h000, "R7", c, 12'h000);

        // R3: release all of word1, unused upper bits written as ones
        do_write(2'b01, 8'hF0);
        settle();
        do_read(2'b01, d);
        check(d == 8'h00, "R3", d, 8'h00);
        check_all("R3");

        // R6: status address write has no effect
        do_write(2'b10, 8'h00);
        do_write(2'b11, 8'hFF);
        settle();
        check_all("R6");

        // R8: repeated reads leave everything as it was
        for (int i = 0; i < 4; i++) do_read(2'b00, d);
        check(d == exp_word(0), "R8", d, exp_word(0));
        check_all("R8");

        // R9 / R3: random read-modify-write traffic
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] a;
            logic [BW-1:0] m;
            a = 2'($urandom_range(0, 1));
            m = 8'($urandom);
            do_read(a, d);
            if ($urandom_range(0, 1) == 1) do_write(a, d | m);
            else                           do_write(a, d & ~m);
            settle();
            check_all("R9");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule